// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block holds a small, fully associative table of segment descriptors. Each entry pairs the upper bits of an effective address (the segment tag) with a descriptor word that names the virtual segment and carries its segment size, page-size code and class bit. Every entry's tag is compared with a presented effective address at the same time. The result is returned one cycle later as a hit flag, the lowest matching slot and that slot's descriptor.

Software-style operations reach the table through separate ports. A write port installs an entry after it screens the operands. Two read ports return either the tag word or the descriptor word of a slot. An invalidate port removes one entry by address, or removes many entries at once under a hint code. Any invalidation that removes state raises a one-cycle request to flush the downstream translation cache, and the request is marked either local or global. A lookup in find mode is refused when the requester is not in 64-bit mode.

Top module: `slb_array`

## Requirements
- R1: An entry whose size code (descriptor bits 63:62) is 00 matches when its 36-bit tag equals address bits 63:28. When the size code is 01 it matches when its tag equals {address bits 63:40, twelve zeros}. The lookup result appears on the outputs on the clock edge after the request.
- R2: Only an entry whose valid flag is set can hit. On a miss, lk_hit_o is 0 and lk_vsid_o is all ones.
- R3: When several entries match, lk_slot_o and lk_vsid_o come from the lowest-numbered matching slot.
- R4: The write operand carries the tag in bits 63:28, the valid flag in bit 27 and the slot in bits 11:0. A slot at or above N_ENTRIES is rejected: wr_err_o pulses and no entry changes.
- R5: A write is also rejected, with wr_err_o and no state change, in four cases: any of operand bits 26:12 is set; descriptor bit 63 is set; size code 01 is given while ONE_TB_EN is 0; or the page-size code (descriptor bits 5:4) is not enabled in PAGE_CODE_OK.
- R6: A read returns {tag, valid, 27 zeros} when rd_vsid_sel_i is 0 and the descriptor word when it is 1. A slot at or above N_ENTRIES sets rd_err_o instead.
- R7: Invalidate-by-address clears the valid flag of the lowest matching entry. It pulses flush_local_o when inv_global_i is 0 and flush_global_o when it is 1. With no match, no entry changes and no flush is raised.
- R8: Invalidate-all clears every valid entry except slot 0 when new_mode_i is 0, or when new_mode_i is 1 with hint 0, 1, 2 or 6. It always pulses flush_local_o.
- R9: With new_mode_i set, hint 3 also covers slot 0 but keeps every entry whose class bit (descriptor bit 7) is 0. Hint 4 clears nothing but still flushes. Hint 7 clears every entry, slot 0 included.
- R10: With new_mode_i set, hint 5 acts as hint 0 and pulses warn_o. With new_mode_i clear, warn_o stays 0.
- R11: A find lookup (lk_find_i set) with mode64_i clear returns lk_err_o = 1 and no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write request |
| wr_esid_i | input | 64 | Tag, valid flag and slot operand |
| wr_vsid_i | input | 64 | Descriptor word to install |
| wr_err_o | output | 1 | Write rejected (one-cycle pulse) |
| rd_valid_i | input | 1 | Read request |
| rd_vsid_sel_i | input | 1 | 0 selects the tag word, 1 selects the descriptor |
| rd_op_i | input | 64 | Read operand, slot in bits 11:0 |
| rd_data_o | output | 64 | Read data |
| rd_err_o | output | 1 | Slot out of range |
| lk_valid_i | input | 1 | Lookup request |
| lk_find_i | input | 1 | Lookup is a find operation |
| mode64_i | input | 1 | Requester is in 64-bit mode |
| lk_ea_i | input | 64 | Effective address to look up |
| lk_hit_o | output | 1 | Lookup hit |
| lk_slot_o | output | IDX_W | Slot that hit |
| lk_vsid_o | output | 64 | Descriptor on a hit, all ones otherwise |
| lk_err_o | output | 1 | Find refused outside 64-bit mode |
| inv_valid_i | input | 1 | Invalidate request |
| inv_all_i | input | 1 | 1 selects invalidate-all, 0 selects by address |
| inv_global_i | input | 1 | By-address form requests a global flush |
| inv_ea_i | input | 64 | Address for invalidate-by-address |
| inv_hint_i | input | 3 | Hint code for invalidate-all |
| new_mode_i | input | 1 | Enables the extended hint codes |
| flush_local_o | output | 1 | Local translation-cache flush request |
| flush_global_o | output | 1 | Global translation-cache flush request |
| warn_o | output | 1 | Undefined hint code seen |

## Verification
Four kinds of behaviour are checked by assertions on every cycle: the error responses to out-of-range slots and to refused find requests, the all-ones descriptor whenever there is no hit, the rule that a global flush comes only from the by-address global form, and the flush and warning raised by invalidate-all. Other behaviour can only be shown by the bench's scenarios, because it depends on the table's contents: the two segment granularities, lowest-slot priority, which entries survive each hint code, and the fact that rejected writes leave the table unchanged.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int TAG_W     = 36;
  localparam int TAG_LSB   = 28;
  localparam int VLD_BIT   = 27;
  localparam int SLOT_W    = 12;
  localparam int TB_LSB    = 40;
  localparam int CLASS_BIT = 7;
  localparam int PG_LSB    = 4;

  localparam logic [1:0] SEG_256M = 2'b00;
  localparam logic [1:0] SEG_1T   = 2'b01;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             vld;
    logic [63:0]      desc;
  } slb_entry_t;
endpackage

// File: rtl/slb_match.sv
module slb_match
  import slb_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  slb_entry_t [N_ENTRIES-1:0] tbl_i,
  input  logic [63:0]                ea_i,
  output logic                       hit_o,
  output logic [IDX_W-1:0]           idx_o
);
  localparam int TB_KEEP = 64 - TB_LSB;

  logic [N_ENTRIES-1:0] m;
  logic [TAG_W-1:0] key_256m, key_1t;

  assign key_256m = ea_i[63:TAG_LSB];
  assign key_1t   = {ea_i[63:TB_LSB], {(TAG_W-TB_KEEP){1'b0}}};

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
    logic [1:0] sz;
    assign sz   = tbl_i[i].desc[63:62];
    assign m[i] = tbl_i[i].vld &&
                  (((sz == SEG_256M) && (tbl_i[i].tag == key_256m)) ||
                   ((sz == SEG_1T)   && (tbl_i[i].tag == key_1t)));
  end

  assign hit_o = |m;

  always_comb begin
    idx_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--)
      if (m[i]) idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/slb_wr_check.sv
module slb_wr_check
  import slb_pkg::*;
#(
  parameter int         N_ENTRIES    = 8,
  parameter bit         ONE_TB_EN    = 1'b1,
  parameter logic [3:0] PAGE_CODE_OK = 4'b0111
) (
  input  logic [63:0] esid_op_i,
  input  logic [63:0] vsid_op_i,
  output logic        ok_o
);
  logic bad_slot, bad_rsvd, bad_size, bad_1t, bad_page;

  assign bad_slot = esid_op_i[SLOT_W-1:0] >= SLOT_W'(N_ENTRIES);
  assign bad_rsvd = |esid_op_i[VLD_BIT-1:SLOT_W];
  assign bad_size = vsid_op_i[63];
  assign bad_1t   = (vsid_op_i[63:62] == SEG_1T) && !ONE_TB_EN;
  assign bad_page = !PAGE_CODE_OK[vsid_op_i[PG_LSB+1:PG_LSB]];

  assign ok_o = !(bad_slot || bad_rsvd || bad_size || bad_1t || bad_page);
endmodule

// File: rtl/slb_inv_all.sv
module slb_inv_all #(
  parameter int N_ENTRIES = 8
) (
  input  logic                 new_mode_i,
  input  logic [2:0]           hint_i,
  input  logic [N_ENTRIES-1:0] vld_i,
  input  logic [N_ENTRIES-1:0] cls_i,
  output logic [N_ENTRIES-1:0] clr_o,
  output logic                 warn_o
);
  logic incl_zero, keep_c0, none;

  always_comb begin
    incl_zero = 1'b0;
    keep_c0   = 1'b0;
    none      = 1'b0;
    warn_o    = 1'b0;
    if (new_mode_i) begin
      unique case (hint_i)
        3'd0, 3'd1, 3'd2, 3'd6: ;
        3'd3: begin incl_zero = 1'b1; keep_c0 = 1'b1; end
        3'd4: none = 1'b1;
        3'd7: incl_zero = 1'b1;
        default: warn_o = 1'b1;
      endcase
    end
  end

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_clr
    if (i == 0) begin : g_zero
      assign clr_o[i] = vld_i[i] && !none && incl_zero && !(keep_c0 && !cls_i[i]);
    end else begin : g_rest
      assign clr_o[i] = vld_i[i] && !none && !(keep_c0 && !cls_i[i]);
    end
  end
endmodule

// File: rtl/slb_array.sv
module slb_array
  import slb_pkg::*;
#(
  parameter int         N_ENTRIES    = 8,
  parameter bit         ONE_TB_EN    = 1'b1,
  parameter logic [3:0] PAGE_CODE_OK = 4'b0111,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [63:0]      wr_esid_i,
  input  logic [63:0]      wr_vsid_i,
  output logic             wr_err_o,
  input  logic             rd_valid_i,
  input  logic             rd_vsid_sel_i,
  input  logic [63:0]      rd_op_i,
  output logic [63:0]      rd_data_o,
  output logic             rd_err_o,
  input  logic             lk_valid_i,
  input  logic             lk_find_i,
  input  logic             mode64_i,
  input  logic [63:0]      lk_ea_i,
  output logic             lk_hit_o,
  output logic [IDX_W-1:0] lk_slot_o,
  output logic [63:0]      lk_vsid_o,
  output logic             lk_err_o,
  input  logic             inv_valid_i,
  input  logic             inv_all_i,
  input  logic             inv_global_i,
  input  logic [63:0]      inv_ea_i,
  input  logic [2:0]       inv_hint_i,
  input  logic             new_mode_i,
  output logic             flush_local_o,
  output logic             flush_global_o,
  output logic             warn_o
);
  slb_entry_t [N_ENTRIES-1:0] tbl_q, tbl_d;
  logic [N_ENTRIES-1:0] vld_vec, cls_vec, clr_vec;
  logic                 lk_m_hit, inv_m_hit, wr_ok, all_warn;
  logic [IDX_W-1:0]     lk_m_idx, inv_m_idx, wr_idx, rd_idx;
  logic                 rd_bad, lk_bad, inv_addr, inv_all;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_vec
    assign vld_vec[i] = tbl_q[i].vld;
    assign cls_vec[i] = tbl_q[i].desc[CLASS_BIT];
  end

  slb_match #(.N_ENTRIES(N_ENTRIES)) i_lk_match (
    .tbl_i(tbl_q), .ea_i(lk_ea_i), .hit_o(lk_m_hit), .idx_o(lk_m_idx));

  slb_match #(.N_ENTRIES(N_ENTRIES)) i_inv_match (
    .tbl_i(tbl_q), .ea_i(inv_ea_i), .hit_o(inv_m_hit), .idx_o(inv_m_idx));

  slb_wr_check #(
    .N_ENTRIES(N_ENTRIES), .ONE_TB_EN(ONE_TB_EN), .PAGE_CODE_OK(PAGE_CODE_OK)
  ) i_wr_check (
    .esid_op_i(wr_esid_i), .vsid_op_i(wr_vsid_i), .ok_o(wr_ok));

  slb_inv_all #(.N_ENTRIES(N_ENTRIES)) i_inv_all (
    .new_mode_i(new_mode_i), .hint_i(inv_hint_i), .vld_i(vld_vec),
    .cls_i(cls_vec), .clr_o(clr_vec), .warn_o(all_warn));

  assign wr_idx   = wr_esid_i[IDX_W-1:0];
  assign rd_idx   = rd_op_i[IDX_W-1:0];
  assign rd_bad   = rd_op_i[SLOT_W-1:0] >= SLOT_W'(N_ENTRIES);
  assign lk_bad   = lk_find_i && !mode64_i;
  assign inv_all  = inv_valid_i && inv_all_i;
  assign inv_addr = inv_valid_i && !inv_all_i && inv_m_hit;

  // invalidation acts on the old table; a same-cycle write to a slot wins
  always_comb begin
    tbl_d = tbl_q;
    if (inv_all) begin
      for (int i = 0; i < N_ENTRIES; i++)
        if (clr_vec[i]) tbl_d[i].vld = 1'b0;
    end else if (inv_addr) begin
      tbl_d[inv_m_idx].vld = 1'b0;
    end
    if (wr_valid_i && wr_ok) begin
      tbl_d[wr_idx].tag  = wr_esid_i[63:TAG_LSB];
      tbl_d[wr_idx].vld  = wr_esid_i[VLD_BIT];
      tbl_d[wr_idx].desc = wr_vsid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_q          <= '0;
      wr_err_o       <= 1'b0;
      rd_data_o      <= '0;
      rd_err_o       <= 1'b0;
      lk_hit_o       <= 1'b0;
      lk_slot_o      <= '0;
      lk_vsid_o      <= '1;
      lk_err_o       <= 1'b0;
      flush_local_o  <= 1'b0;
      flush_global_o <= 1'b0;
      warn_o         <= 1'b0;
    end else begin
      tbl_q          <= tbl_d;
      wr_err_o       <= wr_valid_i && !wr_ok;
      rd_err_o       <= rd_valid_i && rd_bad;
      if (rd_valid_i)
        rd_data_o <= rd_bad ? '0 :
                     rd_vsid_sel_i ? tbl_q[rd_idx].desc :
                     {tbl_q[rd_idx].tag, tbl_q[rd_idx].vld, {VLD_BIT{1'b0}}};
      lk_hit_o       <= lk_valid_i && !lk_bad && lk_m_hit;
      lk_slot_o      <= (lk_valid_i && !lk_bad && lk_m_hit) ? lk_m_idx : '0;
      lk_vsid_o      <= (lk_valid_i && !lk_bad && lk_m_hit) ? tbl_q[lk_m_idx].desc : '1;
      lk_err_o       <= lk_valid_i && lk_bad;
      flush_local_o  <= inv_all || (inv_addr && !inv_global_i);
      flush_global_o <= inv_addr && inv_global_i;
      warn_o         <= inv_all && all_warn;
    end
  end
endmodule

// File: rtl/slb_array_chk.sv
module slb_array_chk #(
  parameter int N_ENTRIES = 8,
  parameter int IDX_W     = 3
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_valid_i,
  input logic [63:0] wr_esid_i,
  input logic        wr_err_o,
  input logic        rd_valid_i,
  input logic [63:0] rd_op_i,
  input logic        rd_err_o,
  input logic        lk_valid_i,
  input logic        lk_find_i,
  input logic        mode64_i,
  input logic        lk_hit_o,
  input logic [63:0] lk_vsid_o,
  input logic        lk_err_o,
  input logic        inv_valid_i,
  input logic        inv_all_i,
  input logic        inv_global_i,
  input logic [2:0]  inv_hint_i,
  input logic        new_mode_i,
  input logic        flush_local_o,
  input logic        flush_global_o,
  input logic        warn_o
);
  AST_MISS_ALL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> lk_vsid_o == '1); // R2

  AST_WR_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && (wr_esid_i[11:0] >= 12'(N_ENTRIES)) |=> wr_err_o); // R4

  AST_RD_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i && (rd_op_i[11:0] >= 12'(N_ENTRIES)) |=> rd_err_o); // R6

  AST_GLOBAL_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inv_valid_i && !inv_all_i && inv_global_i) |=> !flush_global_o); // R7

  AST_ALL_FLUSHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_i && inv_all_i |=> flush_local_o && !flush_global_o); // R8

  AST_WARN_HINT5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_i && inv_all_i && new_mode_i && (inv_hint_i == 3'd5) |=> warn_o); // R10

  AST_WARN_OLD_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inv_valid_i && inv_all_i && new_mode_i) |=> !warn_o); // R10

  AST_FIND_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i && lk_find_i && !mode64_i |=> lk_err_o && !lk_hit_o); // R11
endmodule

bind slb_array slb_array_chk #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) i_chk (.*);

// File: tb/test_slb_array.sv
module test_slb_array;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        wr_valid = 0, rd_valid = 0, rd_sel = 0, lk_valid = 0, lk_find = 0, mode64 = 1;
  logic        inv_valid = 0, inv_all = 0, inv_global = 0, new_mode = 0;
  logic [63:0] wr_esid = 0, wr_vsid = 0, rd_op = 0, lk_ea = 0, inv_ea = 0;
  logic [2:0]  inv_hint = 0;

  logic wr_err, rd_err, lk_hit, lk_err, fl_l, fl_g, warn;
  logic [63:0] rd_data, lk_vsid;
  logic [IW-1:0] lk_slot;
  logic b_wr_err, b_rd_err, b_lk_hit, b_lk_err, b_fl_l, b_fl_g, b_warn;
  logic [63:0] b_rd_data, b_lk_vsid;
  logic [IW-1:0] b_lk_slot;

  int n_cmp = 0, n_err = 0;
  bit done = 0;

  slb_array #(.N_ENTRIES(N)) i_slb_array (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_esid_i(wr_esid), .wr_vsid_i(wr_vsid), .wr_err_o(wr_err),
    .rd_valid_i(rd_valid), .rd_vsid_sel_i(rd_sel), .rd_op_i(rd_op),
    .rd_data_o(rd_data), .rd_err_o(rd_err),
    .lk_valid_i(lk_valid), .lk_find_i(lk_find), .mode64_i(mode64), .lk_ea_i(lk_ea),
    .lk_hit_o(lk_hit), .lk_slot_o(lk_slot), .lk_vsid_o(lk_vsid), .lk_err_o(lk_err),
    .inv_valid_i(inv_valid), .inv_all_i(inv_all), .inv_global_i(inv_global),
    .inv_ea_i(inv_ea), .inv_hint_i(inv_hint), .new_mode_i(new_mode),
    .flush_local_o(fl_l), .flush_global_o(fl_g), .warn_o(warn));

  slb_array #(.N_ENTRIES(N), .ONE_TB_EN(1'b0)) i_slb_array_no1t (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_esid_i(wr_esid), .wr_vsid_i(wr_vsid), .wr_err_o(b_wr_err),
    .rd_valid_i(rd_valid), .rd_vsid_sel_i(rd_sel), .rd_op_i(rd_op),
    .rd_data_o(b_rd_data), .rd_err_o(b_rd_err),
    .lk_valid_i(lk_valid), .lk_find_i(lk_find), .mode64_i(mode64), .lk_ea_i(lk_ea),
    .lk_hit_o(b_lk_hit), .lk_slot_o(b_lk_slot), .lk_vsid_o(b_lk_vsid), .lk_err_o(b_lk_err),
    .inv_valid_i(inv_valid), .inv_all_i(inv_all), .inv_global_i(inv_global),
    .inv_ea_i(inv_ea), .inv_hint_i(inv_hint), .new_mode_i(new_mode),
    .flush_local_o(b_fl_l), .flush_global_o(b_fl_g), .warn_o(b_warn));

  localparam logic [35:0] TAG_E  = 36'h123456789;
  localparam logic [35:0] TAG_1T = {24'hABCDEF, 12'h000};
  localparam logic [63:0] EA_E   = {TAG_E, 28'h0ABCDEF};
  localparam logic [63:0] EA_1T  = {24'hABCDEF, 40'h123456789A};

  function automatic logic [63:0] mk_desc(input logic [1:0] sz, input logic cls,
                                          input logic [1:0] pg, input logic [49:0] tag);
    return {sz, tag, 4'h0, cls, 1'b0, pg, 4'h0};
  endfunction

  function automatic logic [63:0] mk_op(input logic [35:0] tag, input logic v,
                                        input logic [11:0] slot);
    return {tag, v, 15'h0, slot};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [63:0] op, input logic [63:0] desc);
    @(negedge clk);
    wr_valid = 1; wr_esid = op; wr_vsid = desc;
    @(posedge clk); #1;
    wr_valid = 0;
  endtask

  task automatic do_read(input logic sel, input logic [11:0] slot);
    @(negedge clk);
    rd_valid = 1; rd_sel = sel; rd_op = {52'h0, slot};
    @(posedge clk); #1;
    rd_valid = 0;
  endtask

  task automatic do_lookup(input logic [63:0] ea, input logic find, input logic m64);
    @(negedge clk);
    lk_valid = 1; lk_ea = ea; lk_find = find; mode64 = m64;
    @(posedge clk); #1;
    lk_valid = 0; lk_find = 0; mode64 = 1;
  endtask

  task automatic do_inv_addr(input logic [63:0] ea, input logic glob);
    @(negedge clk);
    inv_valid = 1; inv_all = 0; inv_ea = ea; inv_global = glob;
    @(posedge clk); #1;
    inv_valid = 0; inv_global = 0;
  endtask

  task automatic do_inv_all(input logic nm, input logic [2:0] hint);
    @(negedge clk);
    inv_valid = 1; inv_all = 1; new_mode = nm; inv_hint = hint;
    @(posedge clk); #1;
    inv_valid = 0; inv_all = 0; new_mode = 0;
  endtask

  task automatic expect_hit(input logic [63:0] ea, input int slot,
                            input logic [63:0] desc, input string req);
    do_lookup(ea, 0, 1);
    chk(lk_hit === 1'b1, req, 64'(lk_hit), 64'h1);
    chk(lk_slot === IW'(slot), req, 64'(lk_slot), 64'(slot));
    chk(lk_vsid === desc, req, lk_vsid, desc);
  endtask

  task automatic expect_miss(input logic [63:0] ea, input string req);
    do_lookup(ea, 0, 1);
    chk(lk_hit === 1'b0, req, 64'(lk_hit), 64'h0);
    chk(lk_vsid === '1, req, lk_vsid, '1);
  endtask

  task automatic t_reset;
    chk(lk_hit === 1'b0 && fl_l === 1'b0 && fl_g === 1'b0 && wr_err === 1'b0 && warn === 1'b0,
        "R2 reset", {59'h0, lk_hit, fl_l, fl_g, wr_err, warn}, 64'h0);
    chk(lk_vsid === '1, "R2 reset vsid", lk_vsid, '1);
  endtask

  task automatic t_segments;
    do_write(mk_op(TAG_E, 1, 2), mk_desc(2'b00, 0, 2'b00, 50'h1));
    chk(wr_err === 1'b0, "R4 good write", 64'(wr_err), 0);
    expect_hit(EA_E, 2, mk_desc(2'b00, 0, 2'b00, 50'h1), "R1 256M hit");
    expect_miss({TAG_E[35:12], 12'hFFF, 28'h0}, "R1 256M bits 39:28 differ");
    do_write(mk_op(TAG_1T, 1, 5), mk_desc(2'b01, 0, 2'b01, 50'h5));
    expect_hit(EA_1T, 5, mk_desc(2'b01, 0, 2'b01, 50'h5), "R1 1T hit");
    expect_miss({36'h1, 28'h0}, "R2 miss");
  endtask

  task automatic t_invalid_entry;
    do_write(mk_op(36'h777, 0, 4), mk_desc(2'b00, 0, 2'b00, 50'h4));
    expect_miss({36'h777, 28'h0}, "R2 entry not valid");
  endtask

  task automatic t_priority;
    do_write(mk_op(36'h555, 1, 3), mk_desc(2'b00, 0, 2'b00, 50'h33));
    do_write(mk_op(36'h555, 1, 1), mk_desc(2'b00, 0, 2'b00, 50'h11));
    expect_hit({36'h555, 28'h1}, 1, mk_desc(2'b00, 0, 2'b00, 50'h11), "R3 lowest slot");
  endtask

  task automatic t_write_err;
    do_write(mk_op(36'h999, 1, 12'd8), mk_desc(2'b00, 0, 2'b00, 50'h9));
    chk(wr_err === 1'b1, "R4 slot out of range", 64'(wr_err), 1);
    do_write(mk_op(36'h999, 1, 6) | 64'h1000, mk_desc(2'b00, 0, 2'b00, 50'h9));
    chk(wr_err === 1'b1, "R5 reserved bit", 64'(wr_err), 1);
    do_write(mk_op(36'h999, 1, 6), mk_desc(2'b10, 0, 2'b00, 50'h9));
    chk(wr_err === 1'b1, "R5 bad size code", 64'(wr_err), 1);
    do_write(mk_op(36'h999, 1, 6), mk_desc(2'b00, 0, 2'b11, 50'h9));
    chk(wr_err === 1'b1, "R5 bad page code", 64'(wr_err), 1);
    expect_miss({36'h999, 28'h0}, "R5 rejected writes store nothing");
    do_write(mk_op(TAG_1T, 1, 7), mk_desc(2'b01, 0, 2'b00, 50'h7));
    chk(b_wr_err === 1'b1, "R5 1T without support", 64'(b_wr_err), 1);
    chk(wr_err === 1'b0, "R5 1T with support", 64'(wr_err), 0);
    do_inv_addr(EA_1T, 0); // drop slot 5 copy so slot 5 and 7 stay distinct
    do_write(mk_op(TAG_1T, 1, 5), mk_desc(2'b01, 0, 2'b01, 50'h5));
    do_write(mk_op(36'h0, 0, 7), mk_desc(2'b00, 0, 2'b00, 50'h0));
  endtask

  task automatic t_read;
    do_read(0, 2);
    chk(rd_data === {TAG_E, 1'b1, 27'h0} && rd_err === 1'b0, "R6 tag read", rd_data,
        {TAG_E, 1'b1, 27'h0});
    do_read(1, 2);
    chk(rd_data === mk_desc(2'b00, 0, 2'b00, 50'h1), "R6 descriptor read", rd_data,
        mk_desc(2'b00, 0, 2'b00, 50'h1));
    do_read(1, 9);
    chk(rd_err === 1'b1, "R6 slot out of range", 64'(rd_err), 1);
  endtask

  task automatic t_inv_addr;
    do_inv_addr({36'h555, 28'h0}, 0);
    chk(fl_l === 1'b1 && fl_g === 1'b0, "R7 local flush", {fl_l, fl_g}, 64'h2);
    expect_hit({36'h555, 28'h0}, 3, mk_desc(2'b00, 0, 2'b00, 50'h33), "R7 next copy remains");
    do_inv_addr({36'h555, 28'h0}, 1);
    chk(fl_l === 1'b0 && fl_g === 1'b1, "R7 global flush", {fl_l, fl_g}, 64'h1);
    expect_miss({36'h555, 28'h0}, "R7 entry cleared");
    do_inv_addr({36'hAAA, 28'h0}, 1);
    chk(fl_l === 1'b0 && fl_g === 1'b0, "R7 no match no flush", {fl_l, fl_g}, 64'h0);
    expect_hit(EA_E, 2, mk_desc(2'b00, 0, 2'b00, 50'h1), "R7 no match keeps table");
  endtask

  task automatic t_inv_all_default;
    do_write(mk_op(36'h100, 1, 0), mk_desc(2'b00, 0, 2'b00, 50'h100));
    do_inv_all(0, 3'd3);
    chk(fl_l === 1'b1 && fl_g === 1'b0, "R8 flush", {fl_l, fl_g}, 64'h2);
    expect_hit({36'h100, 28'h0}, 0, mk_desc(2'b00, 0, 2'b00, 50'h100), "R8 slot 0 kept");
    expect_miss(EA_E, "R8 slot 2 cleared");
    expect_miss(EA_1T, "R8 slot 5 cleared");
  endtask

  task automatic t_hints;
    do_write(mk_op(36'h100, 1, 0), mk_desc(2'b00, 1, 2'b00, 50'h100));
    do_write(mk_op(TAG_E, 1, 2), mk_desc(2'b00, 0, 2'b00, 50'h1));
    do_write(mk_op(TAG_1T, 1, 5), mk_desc(2'b01, 1, 2'b01, 50'h5));
    do_inv_all(1, 3'd4);
    chk(fl_l === 1'b1, "R9 hint 4 flush", 64'(fl_l), 1);
    expect_hit(EA_E, 2, mk_desc(2'b00, 0, 2'b00, 50'h1), "R9 hint 4 keeps entries");
    do_inv_all(1, 3'd3);
    expect_miss({36'h100, 28'h0}, "R9 hint 3 clears class-1 slot 0");
    expect_miss(EA_1T, "R9 hint 3 clears class-1 slot 5");
    expect_hit(EA_E, 2, mk_desc(2'b00, 0, 2'b00, 50'h1), "R9 hint 3 keeps class 0");
    do_write(mk_op(36'h100, 1, 0), mk_desc(2'b00, 0, 2'b00, 50'h100));
    do_inv_all(1, 3'd7);
    expect_miss({36'h100, 28'h0}, "R9 hint 7 clears slot 0");
    expect_miss(EA_E, "R9 hint 7 clears slot 2");
  endtask

  task automatic t_warn;
    do_write(mk_op(36'h100, 1, 0), mk_desc(2'b00, 0, 2'b00, 50'h100));
    do_write(mk_op(TAG_E, 1, 2), mk_desc(2'b00, 0, 2'b00, 50'h1));
    do_inv_all(1, 3'd5);
    chk(warn === 1'b1 && fl_l === 1'b1, "R10 warn on hint 5", {warn, fl_l}, 64'h3);
    expect_hit({36'h100, 28'h0}, 0, mk_desc(2'b00, 0, 2'b00, 50'h100), "R10 slot 0 kept");
    expect_miss(EA_E, "R10 acts as hint 0");
    do_write(mk_op(TAG_E, 1, 2), mk_desc(2'b00, 0, 2'b00, 50'h1));
    do_inv_all(0, 3'd5);
    chk(warn === 1'b0, "R10 no warn in old mode", 64'(warn), 0);
    expect_miss(EA_E, "R10 old mode clears");
  endtask

  task automatic t_find;
    do_write(mk_op(TAG_E, 1, 2), mk_desc(2'b00, 0, 2'b00, 50'h1));
    do_lookup(EA_E, 1, 0);
    chk(lk_err === 1'b1 && lk_hit === 1'b0, "R11 refused", {lk_err, lk_hit}, 64'h2);
    do_lookup(EA_E, 1, 1);
    chk(lk_err === 1'b0 && lk_hit === 1'b1, "R11 allowed in 64-bit", {lk_err, lk_hit}, 64'h1);
    do_lookup({36'h3, 28'h0}, 1, 1);
    chk(lk_vsid === '1, "R2 find miss all ones", lk_vsid, '1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_segments();
    t_invalid_entry();
    t_priority();
    t_write_err();
    t_read();
    t_inv_addr();
    t_inv_all_default();
    t_hints();
    t_warn();
    t_find();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule